// File: doc/BRIEF.md
# Free-Running Timer with Edge Capture

This block is a free-running 16-bit up-counter with three edge-capture channels. A prescaler paces the counter at one of four rates taken from the system clock. Nothing can stop or reload the count; it only advances. When the count wraps from its highest value back to zero, a sticky wrap flag is set. Each capture channel watches one input pin. When the chosen edge type arrives, the channel stores the current count in its own 16-bit register and sets its sticky flag. The count is also driven out of the block for other timer functions that share the same timebase.

Software reaches the block through a small single-cycle register port. The port has a write strobe, an address, write data and read data that is valid in the same cycle. The prescaler code is an enumeration named DIV_1, DIV_4, DIV_8 and DIV_16. The per-channel edge mode is an enumeration named EDGE_OFF, EDGE_RISE, EDGE_FALL and EDGE_BOTH. Both are decoded with unique case statements, and neither has a sequenced state.

The register map by address:

- Address 0 (count): the current count, read-only.
- Address 1 (control): bits [1:0] hold the prescaler code. Bits [2i+3:2i+2] hold the edge mode of channel i.
- Address 2 (mask): bit i arms the interrupt of channel i, and bit 3 arms the wrap interrupt.
- Address 3 (flags): the flags, laid out with the same bit positions as the mask register.
- Address 4 + i: the capture register of channel i, read-only.

A single interrupt line is driven high whenever any flag is set together with its mask bit.

Top module: `tcap_timer`

## Requirements
- R1: While reset is asserted, the count, the control register, the mask register, all flags, all capture registers and irq are zero.
- R2: The count advances by one every 1, 4, 8 or 16 clock cycles, for prescaler codes 00, 01, 10 and 11 in control bits [1:0].
- R3: A write to the count address (0) has no effect. The count keeps advancing through that write.
- R4: On the clock edge where the count goes from 0xFFFF to 0x0000, the wrap flag (flags bit 3) becomes set.
- R5: The edge mode of channel i sits in control bits [2i+3:2i+2]: 00 = no capture, 01 = rising edges only, 10 = falling edges only, 11 = both edges. An edge that the mode does not select leaves both the flag and the capture register unchanged.
- R6: Each pin passes through a two-flop synchronizer. Suppose a pin changes between two clock edges. The capture register then receives the count value held just after the second rising clock edge that follows the change, and the flag and capture register update on the third edge.
- R7: Writing the flags address clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 are left unchanged.
- R8: If a clearing write and a new event for the same flag reach the same clock edge, the flag stays set.
- R9: irq is high exactly when some flag bit and the mask bit in the same position are both 1.
- R10: Control and mask read back as written. A write to a capture address leaves that capture register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data, same cycle |
| cap_pin | input | 3 | Capture input pins, one per channel |
| count_o | output | 16 | Current count, for other timer functions |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit count and three channels. With these values every combination of channel and edge mode can be swept, rising and falling edges alike. The bench also runs each of the four prescaler codes over a fixed 64-cycle window. Because the count is only 16 bits wide, a real wrap from 0xFFFF to zero occurs within the run at the divide-by-one rate, so the wrap flag and its interrupt are seen at the cycle where they happen. Expected capture values come from sampling the exported count two edges after each pin change.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    typedef enum logic [1:0] {
        DIV_1  = 2'b00,
        DIV_4  = 2'b01,
        DIV_8  = 2'b10,
        DIV_16 = 2'b11
    } tcap_div_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } tcap_edge_e;

    localparam int ADR_COUNT = 0;
    localparam int ADR_CTRL  = 1;
    localparam int ADR_MASK  = 2;
    localparam int ADR_FLAG  = 3;
    localparam int ADR_CAP0  = 4;

    localparam int PS_W = 4;

    // Last prescaler count value before a tick, for each division code.
    function automatic logic [PS_W-1:0] div_limit(input tcap_div_e code);
        logic [PS_W-1:0] lim;
        unique case (code)
            DIV_1:   lim = 4'd0;
            DIV_4:   lim = 4'd3;
            DIV_8:   lim = 4'd7;
            DIV_16:  lim = 4'd15;
            default: lim = 4'd0;
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/tcap_timebase.sv
module tcap_timebase
    import tcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tcap_div_e        div_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);

    logic [PS_W-1:0]  ps_q;
    logic [CNT_W-1:0] count_q;
    logic             tick;

    // A >= compare keeps the divider sane when the code shrinks mid-period.
    assign tick = (ps_q >= div_limit(div_i));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q    <= '0;
            count_q <= '0;
        end else if (tick) begin
            ps_q    <= '0;
            count_q <= count_q + 1'b1;
        end else begin
            ps_q    <= ps_q + 1'b1;
        end
    end

    assign count_o = count_q;
    assign wrap_o  = tick && (count_q == {CNT_W{1'b1}});

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != $past(count_q)) |-> (count_q == CNT_W'($past(count_q) + 1)));

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $past(tick)) |-> (div_i == DIV_1));

endmodule

// File: rtl/tcap_sync.sv
module tcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
    import tcap_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  tcap_edge_e       mode_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             clr_i,
    output logic             flag_o,
    output logic [CNT_W-1:0] cap_o
);

    logic             pin_s;
    logic             prev_q;
    logic             rise;
    logic             fall;
    logic             evt;
    logic             flag_q;
    logic [CNT_W-1:0] cap_q;

    tcap_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_s)
    );

    assign rise = pin_s & ~prev_q;
    assign fall = ~pin_s & prev_q;

    always_comb begin
        unique case (mode_i)
            EDGE_OFF:  evt = 1'b0;
            EDGE_RISE: evt = rise;
            EDGE_FALL: evt = fall;
            EDGE_BOTH: evt = rise | fall;
            default:   evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
            cap_q  <= '0;
        end else begin
            prev_q <= pin_s;
            // A new event outranks a clearing write in the same cycle.
            flag_q <= evt | (flag_q & ~clr_i);
            if (evt) cap_q <= count_i;
        end
    end

    assign flag_o = flag_q;
    assign cap_o  = cap_q;

    // R5
    flag_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> ($past(mode_i) != EDGE_OFF));

    // R6
    cap_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_q) |-> flag_q);

endmodule

// File: rtl/tcap_timer.sv
module tcap_timer
    import tcap_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NCH    = 3,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [NCH-1:0]    cap_pin,
    output logic [CNT_W-1:0]  count_o,
    output logic              irq
);

    localparam int CTRL_W = 2 + 2 * NCH;
    localparam int FLG_W  = NCH + 1;
    localparam int OVF_B  = NCH;

    logic [CTRL_W-1:0] ctrl_q;
    logic [FLG_W-1:0]  mask_q;
    logic [FLG_W-1:0]  clr_vec;
    logic [FLG_W-1:0]  flags;
    logic              ovf_q;
    logic              wrap;
    logic [NCH-1:0]    ch_flag;
    logic [CNT_W-1:0]  cap [NCH];
    logic [CNT_W-1:0]  cnt;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[CNT_W-1:CTRL_W];

    tcap_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_i   (tcap_div_e'(ctrl_q[1:0])),
        .count_o (cnt),
        .wrap_o  (wrap)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tcap_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (cap_pin[g]),
            .mode_i  (tcap_edge_e'(ctrl_q[2+2*g +: 2])),
            .count_i (cnt),
            .clr_i   (clr_vec[g]),
            .flag_o  (ch_flag[g]),
            .cap_o   (cap[g])
        );
    end

    assign clr_vec = (bus_wr && bus_addr == ADDR_W'(ADR_FLAG)) ? bus_wdata[FLG_W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == ADDR_W'(ADR_CTRL)) ctrl_q <= bus_wdata[CTRL_W-1:0];
            if (bus_wr && bus_addr == ADDR_W'(ADR_MASK)) mask_q <= bus_wdata[FLG_W-1:0];
            ovf_q <= wrap | (ovf_q & ~clr_vec[OVF_B]);
        end
    end

    assign flags   = {ovf_q, ch_flag};
    assign irq     = |(flags & mask_q);
    assign count_o = cnt;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADR_COUNT)) bus_rdata = cnt;
        if (bus_addr == ADDR_W'(ADR_CTRL))  bus_rdata = CNT_W'(ctrl_q);
        if (bus_addr == ADDR_W'(ADR_MASK))  bus_rdata = CNT_W'(mask_q);
        if (bus_addr == ADDR_W'(ADR_FLAG))  bus_rdata = CNT_W'(flags);
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ADDR_W'(ADR_CAP0 + i)) bus_rdata = cap[i];
        end
    end

    // R4
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && $past(cnt) == {CNT_W{1'b1}}) |-> ovf_q);

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

endmodule

// File: tb/test_tcap_timer.sv
module test_tcap_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  cap_pin = '0;
    logic [15:0] count_o;
    logic        irq;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    tcap_timer i_tcap_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_pin   (cap_pin),
        .count_o   (count_o),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a[2:0];
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a[2:0];
        #1 d = bus_rdata;
    endtask

    // Change a pin, return the count the capture should take, stop after the third edge.
    task automatic drive_pin(input int c, input logic v, output logic [15:0] exp_cnt);
        @(negedge clk);
        cap_pin[c] = v;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        exp_cnt = count_o;
        @(posedge clk);
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] d, v, w, e, prev;
        int lens [4] = '{1, 4, 8, 16};

        // R1 reset state
        repeat (3) @(posedge clk);
        rd(0, d); chk("R1 count", d, 0);
        rd(1, d); chk("R1 control", d, 0);
        rd(2, d); chk("R1 mask", d, 0);
        rd(3, d); chk("R1 flags", d, 0);
        for (int i = 0; i < 3; i++) begin
            rd(4 + i, d); chk("R1 capture", d, 0);
        end
        chk("R1 irq", irq, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 prescaler sweep over all four codes
        for (int p = 0; p < 4; p++) begin
            wr(1, 16'(p));
            @(negedge clk);
            v = count_o;
            repeat (64) @(posedge clk);
            @(negedge clk);
            w = count_o;
            chk("R2 advance", 16'(w - v), 16'(64 / lens[p]));
        end
        wr(1, 16'h0000);

        // R3 writing the count address is ignored
        @(negedge clk);
        v = count_o;
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h0000;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R3 count runs through write", count_o, 16'(v + 1));

        // R10 readback and read-only capture
        wr(2, 16'h0005);
        rd(2, d); chk("R10 mask readback", d, 16'h0005);
        wr(1, 16'h00A4);
        rd(1, d); chk("R10 control readback", d, 16'h00A4);
        wr(1, 16'h0000);
        wr(2, 16'h0000);
        wr(4, 16'h1234);
        rd(4, d); chk("R10 capture read-only", d, 16'h0000);

        // R5 R6 exhaustive channel by edge-mode sweep
        for (int c = 0; c < 3; c++) begin
            for (int m = 0; m < 4; m++) begin
                wr(1, 16'(m << (2 + 2 * c)));
                wr(3, 16'h000F);
                rd(4 + c, prev);
                drive_pin(c, 1'b1, e);
                rd(3, d);
                chk("R5 rise flag", d[2:0], (m == 1 || m == 3) ? 3'(1 << c) : 3'b000);
                rd(4 + c, d);
                chk("R6 rise capture", d, (m == 1 || m == 3) ? e : prev);
                prev = d;
                wr(3, 16'h000F);
                drive_pin(c, 1'b0, e);
                rd(3, d);
                chk("R5 fall flag", d[2:0], (m == 2 || m == 3) ? 3'(1 << c) : 3'b000);
                rd(4 + c, d);
                chk("R6 fall capture", d, (m == 2 || m == 3) ? e : prev);
            end
        end

        // R7 write-one-to-clear
        wr(1, 16'h003C);
        wr(3, 16'h000F);
        @(negedge clk);
        cap_pin[1:0] = 2'b11;
        settle();
        rd(3, d); chk("R7 both set", d[2:0], 3'b011);
        wr(3, 16'h0001);
        rd(3, d); chk("R7 clear bit0 only", d[2:0], 3'b010);
        wr(3, 16'h0000);
        rd(3, d); chk("R7 zero write keeps", d[2:0], 3'b010);
        wr(3, 16'h0002);
        rd(3, d); chk("R7 clear bit1", d[2:0], 3'b000);
        wr(1, 16'h0000);
        @(negedge clk);
        cap_pin[1:0] = 2'b00;
        settle();

        // R8 event beats a same-cycle clear
        wr(1, 16'h0040);
        wr(3, 16'h000F);
        @(negedge clk);
        cap_pin[2] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 16'h0004;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(3, d); chk("R8 event wins", d[2], 1'b1);
        wr(3, 16'h0004);
        rd(3, d); chk("R8 later clear works", d[2], 1'b0);
        wr(1, 16'h0000);
        @(negedge clk);
        cap_pin[2] = 1'b0;
        settle();

        // R9 interrupt gating
        wr(1, 16'h0010);
        wr(3, 16'h000F);
        @(negedge clk);
        cap_pin[1] = 1'b1;
        settle();
        @(negedge clk); chk("R9 unmasked flag quiet", irq, 1'b0);
        wr(2, 16'h0002);
        chk("R9 masked flag raises", irq, 1'b1);
        wr(2, 16'h0001);
        chk("R9 other mask quiet", irq, 1'b0);
        wr(2, 16'h0002);
        wr(3, 16'h0002);
        chk("R9 cleared flag quiet", irq, 1'b0);
        wr(1, 16'h0000);
        @(negedge clk);
        cap_pin[1] = 1'b0;
        settle();

        // R4 wrap flag and its interrupt
        wr(2, 16'h0008);
        wr(3, 16'h000F);
        do @(negedge clk); while (count_o != 16'hFFFD);
        chk("R4 no flag before wrap", irq, 1'b0);
        @(negedge clk);
        @(negedge clk);
        chk("R4 at top", count_o, 16'hFFFF);
        chk("R4 still quiet at top", irq, 1'b0);
        @(negedge clk);
        chk("R4 wrapped to zero", count_o, 16'h0000);
        chk("R4 wrap irq", irq, 1'b1);
        rd(3, d); chk("R4 wrap flag", d[3], 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule